// File: doc/BRIEF.md
# Dual-Side Parallel Port Adapter with Edge Interrupts

This block is a parallel I/O adapter with two identical sides, A and B, reached over a small CPU register bus. Each side has an 8-bit port with its own direction and output registers, an edge-sensitive input line (C1), and a second control line (C2). C2 can be an edge-sensitive input, a level output or a strobe output. Each side has two interrupt flags and an interrupt request output.

Software sets up a side through its control register. That register decides whether a port access reaches the direction register or the output latch. It also selects the active edge of each line, enables the interrupts and chooses how C2 behaves. Reading a side's port clears that side's interrupt flags.

The two sides differ only in strobe handshaking. Side A pulls C2 low on a port read. Side B pulls C2 low on a port write, and releases it only when a later port read clears a pending C1 flag.

Top module: `pio_adapter`

## Requirements
- R1: The register select maps 0 to port A, 1 to control A, 2 to port B and 3 to control B.
- R2: Control bit 2 routes port reads and writes: 0 reaches the direction register, 1 reaches the output latch.
- R3: A control read returns the C1 flag in bit 7, the C2 flag in bit 6 and the stored control bits 5..0. Writes to bits 7 and 6 have no effect on the flags.
- R4: A port read while control bit 2 is 1 clears both flags of that side. A port read with bit 2 at 0 leaves them unchanged.
- R5: The C1 flag is set one clock after C1 changes level in the direction selected by control bit 1 (1 = rising, 0 = falling). A change in the other direction sets nothing.
- R6: While control bit 5 is 0, C2 is an input whose flag follows the same rule as C1, with bit 4 as the polarity. While bit 5 is 1, C2 changes set no flag.
- R7: The interrupt output equals (C1 flag AND bit 0) OR (C2 flag AND bit 3 AND C2 is an input).
- R8: With bits 5 and 4 both set, C2 is driven (oe = 1) to the value of bit 3. A control write of 0x34 drives it low and 0x3C drives it high.
- R9: Side A strobe mode (bit 5 = 1, bit 4 = 0): C2 idles high and goes low after a port read with bit 2 set. With bit 3 = 1 it returns high one cycle later. With bit 3 = 0 it returns high on the next active C1 edge.
- R10: Side B strobe mode: C2 goes low after a port write with bit 2 set. With bit 3 = 1 it returns high one cycle later. With bit 3 = 0 it returns high only when a port read clears a set C1 flag.
- R11: When bit 2 is 1, each port read bit returns the output latch where its direction bit is 1 and the pin input where it is 0.
- R12: After reset all direction, latch and control registers are zero: ports are inputs, C2 outputs are disabled and the interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Side A pin inputs |
| pa_out | output | 8 | Side A output latch |
| pa_dir | output | 8 | Side A direction (1 = output) |
| ca1 | input | 1 | Side A edge input |
| ca2_in | input | 1 | Side A second line, input value |
| ca2_out | output | 1 | Side A second line, driven value |
| ca2_oe | output | 1 | Side A second line, output enable |
| irq_a | output | 1 | Side A interrupt request |
| pb_in | input | 8 | Side B pin inputs |
| pb_out | output | 8 | Side B output latch |
| pb_dir | output | 8 | Side B direction (1 = output) |
| cb1 | input | 1 | Side B edge input |
| cb2_in | input | 1 | Side B second line, input value |
| cb2_out | output | 1 | Side B second line, driven value |
| cb2_oe | output | 1 | Side B second line, output enable |
| irq_b | output | 1 | Side B interrupt request |

## Verification
A wrong flag bit appears on the very next control read and, when its enable is set, on the interrupt output one clock after the edge that caused it. A stale or misrouted strobe state appears on the C2 output pair within one or two cycles of the triggering port access. A strobe that never releases stays low across the idle cycles the bench inserts. Routing errors between the direction register and the output latch show up on the next port read, or directly on the direction and latch pins.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // control register bit positions (software depends on these)
    localparam int CB_C1_EN    = 0;
    localparam int CB_C1_RISE  = 1;
    localparam int CB_DATA_SEL = 2;
    localparam int CB_C2_LO    = 3;
    localparam int CB_C2_HI    = 4;
    localparam int CB_C2_DRIVE = 5;
    localparam int CTL_BITS    = 6;

    typedef logic [CTL_BITS-1:0] ctl_t;

    typedef enum logic [1:0] {
        C2M_INPUT  = 2'd0,
        C2M_STROBE = 2'd1,
        C2M_LEVEL  = 2'd2
    } c2_mode_e;

    function automatic c2_mode_e c2_mode(input ctl_t c);
        if (!c[CB_C2_DRIVE])
            return C2M_INPUT;
        else if (c[CB_C2_HI])
            return C2M_LEVEL;
        else
            return C2M_STROBE;
    endfunction

endpackage

// File: rtl/pio_edge_det.sv
module pio_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // level moved and now sits at the polarity asked for
    assign hit = (lvl ^ prev_q) & (lvl == rise_sel);

endmodule

// File: rtl/pio_side.sv
module pio_side
    import pio_pkg::*;
#(
    parameter int W    = 8,
    parameter bit IS_B = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_ctl,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_dir,
    input  logic         c1,
    input  logic         c2_in,
    output logic         c2_out,
    output logic         c2_oe,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
        ctl_t         ctl;
        logic         f1;
        logic         f2;
        logic         stb;
    } side_t;

    side_t s_d, s_q;

    logic     hit1, hit2_raw, hit2;
    logic     data_rd, data_wr, ctl_wr, clr;
    logic     stb_nx;
    c2_mode_e mode;
    logic [W-1:0] port_view;
    logic [1:0]   unused_wbits;

    assign unused_wbits = wdata[7:6];

    pio_edge_det i_c1_det (
        .clk(clk), .rst_n(rst_n), .lvl(c1),
        .rise_sel(s_q.ctl[CB_C1_RISE]), .hit(hit1)
    );

    pio_edge_det i_c2_det (
        .clk(clk), .rst_n(rst_n), .lvl(c2_in),
        .rise_sel(s_q.ctl[CB_C2_HI]), .hit(hit2_raw)
    );

    assign mode    = c2_mode(s_q.ctl);
    assign hit2    = hit2_raw & (mode == C2M_INPUT);
    assign data_rd = rd_en & ~acc_ctl;
    assign data_wr = wr_en & ~acc_ctl;
    assign ctl_wr  = wr_en & acc_ctl;
    assign clr     = data_rd & s_q.ctl[CB_DATA_SEL];

    assign port_view = (s_q.dir & s_q.lat) | (~s_q.dir & pin_in);

    // strobe handling differs per side
    generate
        if (IS_B) begin : g_strobe_b
            always_comb begin
                stb_nx = s_q.stb;
                if (mode == C2M_STROBE) begin
                    if (!s_q.stb && (s_q.ctl[CB_C2_LO] || (clr && s_q.f1)))
                        stb_nx = 1'b1;
                    if (data_wr && s_q.ctl[CB_DATA_SEL])
                        stb_nx = 1'b0;
                end
            end
        end else begin : g_strobe_a
            always_comb begin
                stb_nx = s_q.stb;
                if (mode == C2M_STROBE) begin
                    if (!s_q.stb && (s_q.ctl[CB_C2_LO] || hit1))
                        stb_nx = 1'b1;
                    if (clr)
                        stb_nx = 1'b0;
                end
            end
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (data_wr) begin
            if (s_q.ctl[CB_DATA_SEL]) s_d.lat = wdata[W-1:0];
            else                      s_d.dir = wdata[W-1:0];
        end
        if (clr) begin
            s_d.f1 = 1'b0;
            s_d.f2 = 1'b0;
        end
        if (hit1) s_d.f1 = 1'b1;
        if (hit2) s_d.f2 = 1'b1;
        s_d.stb = stb_nx;
        if (ctl_wr) begin
            s_d.ctl = wdata[CTL_BITS-1:0];
            s_d.stb = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.stb <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (acc_ctl)
            rdata = {s_q.f1, s_q.f2, s_q.ctl};
        else if (s_q.ctl[CB_DATA_SEL])
            rdata = port_view;
        else
            rdata = s_q.dir;
    end

    assign pin_out = s_q.lat;
    assign pin_dir = s_q.dir;
    assign c2_oe   = s_q.ctl[CB_C2_DRIVE];

    always_comb begin
        unique case (mode)
            C2M_LEVEL:  c2_out = s_q.ctl[CB_C2_LO];
            C2M_STROBE: c2_out = s_q.stb;
            default:    c2_out = 1'b0;
        endcase
    end

    assign irq = (s_q.f1 & s_q.ctl[CB_C1_EN]) |
                 (s_q.f2 & s_q.ctl[CB_C2_LO] & (mode == C2M_INPUT));

    AST_DIR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !s_q.ctl[CB_DATA_SEL] |=> pin_dir == $past(wdata[W-1:0])); // R2

    AST_FLAG_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !hit1 && !clr |=> s_q.f1 == $past(s_q.f1)); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !hit1 && !hit2 |=> !s_q.f1 && !s_q.f2); // R4

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit1 |=> s_q.f1); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctl[CB_C1_EN] && !s_q.ctl[CB_C2_LO] |-> !irq); // R7

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode == C2M_STROBE && s_q.ctl[CB_C2_LO] && !c2_out &&
        !wr_en && !clr |=> c2_out); // R9

endmodule

// File: rtl/pio_adapter.sv
module pio_adapter #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_dir,
    input  logic              ca1,
    input  logic              ca2_in,
    output logic              ca2_out,
    output logic              ca2_oe,
    output logic              irq_a,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_dir,
    input  logic              cb1,
    input  logic              cb2_in,
    output logic              cb2_out,
    output logic              cb2_oe,
    output logic              irq_b
);
    localparam int NSIDE = 2;

    logic [PORT_W-1:0] s_pin_in  [NSIDE];
    logic [PORT_W-1:0] s_pin_out [NSIDE];
    logic [PORT_W-1:0] s_pin_dir [NSIDE];
    logic [7:0]        s_rdata   [NSIDE];
    logic [NSIDE-1:0]  s_c1, s_c2_in, s_c2_out, s_c2_oe, s_irq;

    assign s_pin_in[0] = pa_in;
    assign s_pin_in[1] = pb_in;
    assign s_c1        = {cb1, ca1};
    assign s_c2_in     = {cb2_in, ca2_in};

    generate
        for (genvar g = 0; g < NSIDE; g++) begin : g_side
            pio_side #(.W(PORT_W), .IS_B(g == 1)) i_side (
                .clk     (clk),
                .rst_n   (rst_n),
                .acc_ctl (sel[0]),
                .rd_en   (rd & (sel[1] == g[0])),
                .wr_en   (wr & (sel[1] == g[0])),
                .wdata   (wdata),
                .rdata   (s_rdata[g]),
                .pin_in  (s_pin_in[g]),
                .pin_out (s_pin_out[g]),
                .pin_dir (s_pin_dir[g]),
                .c1      (s_c1[g]),
                .c2_in   (s_c2_in[g]),
                .c2_out  (s_c2_out[g]),
                .c2_oe   (s_c2_oe[g]),
                .irq     (s_irq[g])
            );
        end
    endgenerate

    assign rdata   = sel[1] ? s_rdata[1] : s_rdata[0];
    assign pa_out  = s_pin_out[0];
    assign pb_out  = s_pin_out[1];
    assign pa_dir  = s_pin_dir[0];
    assign pb_dir  = s_pin_dir[1];
    assign ca2_out = s_c2_out[0];
    assign cb2_out = s_c2_out[1];
    assign ca2_oe  = s_c2_oe[0];
    assign cb2_oe  = s_c2_oe[1];
    assign irq_a   = s_irq[0];
    assign irq_b   = s_irq[1];

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !irq_a && !irq_b && !ca2_oe && !cb2_oe); // R12

endmodule

// File: tb/test_pio_adapter.sv
`timescale 1ns/1ps
module test_pio_adapter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h3C, pa_out, pa_dir;
    logic [7:0] pb_in = 8'h99, pb_out, pb_dir;
    logic       ca1 = 1'b0, ca2_in = 1'b0, ca2_out, ca2_oe, irq_a;
    logic       cb1 = 1'b0, cb2_in = 1'b0, cb2_out, cb2_oe, irq_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam int SRC_RD = 0, SRC_IRQ = 1, SRC_C2 = 2, SRC_PAO = 3,
                   SRC_PAD = 4, SRC_PBO = 5, SRC_PBD = 6;

    typedef struct {
        string      tag;
        int         src;
        logic [7:0] val;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    pio_adapter i_pio_adapter (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .ca1(ca1), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe), .irq_a(irq_a),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
        .cb1(cb1), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe), .irq_b(irq_b)
    );

    function automatic logic [7:0] observe(int src);
        case (src)
            SRC_RD:  return rdata;
            SRC_IRQ: return {6'b0, irq_a, irq_b};
            SRC_C2:  return {4'b0, ca2_oe, ca2_out, cb2_oe, cb2_out};
            SRC_PAO: return pa_out;
            SRC_PAD: return pa_dir;
            SRC_PBO: return pb_out;
            default: return pb_dir;
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e   = exp_q.pop_front();
            act = observe(e.src);
            n_checks++;
            if (act !== e.val) begin
                n_fail++;
                $display("FAIL %s: actual %02h expected %02h", e.tag, act, e.val);
            end
        end
    end

    task automatic push(string tag, int src, logic [7:0] v);
        exp_t e;
        e.tag = tag; e.src = src; e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #2;
    endtask

    task automatic wr_reg(logic [1:0] s, logic [7:0] d);
        @(posedge clk); #2;
        sel = s; wdata = d; wr = 1'b1;
        @(posedge clk); #2;
        wr = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] s, logic [7:0] v, string tag);
        @(posedge clk); #2;
        sel = s; rd = 1'b1;
        push(tag, SRC_RD, v);
        @(posedge clk); #2;
        rd = 1'b0;
    endtask

    task automatic chk(int src, logic [7:0] v, string tag);
        push(tag, src, v);
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R12 reset state
        chk(SRC_PAD, 8'h00, "R12 dir A");
        chk(SRC_PBO, 8'h00, "R12 latch B");
        chk(SRC_IRQ, 8'h00, "R12 irq");
        chk(SRC_C2,  8'h00, "R12 c2");
        rd_chk(2'd0, 8'h00, "R12 port A");
        rd_chk(2'd3, 8'h00, "R12 ctl B");

        // R1 R2 R11 routing
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'hF0);
        chk(SRC_PAD, 8'hF0, "R2 dir write");
        wr_reg(2'd1, 8'h04);
        wr_reg(2'd0, 8'hA5);
        chk(SRC_PAO, 8'hA5, "R2 latch write");
        chk(SRC_PAD, 8'hF0, "R2 dir kept");
        rd_chk(2'd0, 8'hAC, "R11 mixed read");
        wr_reg(2'd1, 8'h00);
        rd_chk(2'd0, 8'hF0, "R2 dir read");
        wr_reg(2'd3, 8'h04);
        wr_reg(2'd2, 8'h5A);
        chk(SRC_PBO, 8'h5A, "R1 side B latch");
        chk(SRC_PAO, 8'hA5, "R1 side A untouched");
        rd_chk(2'd2, 8'h99, "R11 side B pins");
        rd_chk(2'd3, 8'h04, "R1 ctl B");

        // R3 flag bits not writable
        wr_reg(2'd1, 8'hC4);
        rd_chk(2'd1, 8'h04, "R3 write top bits");

        // R5 edges, R7 irq
        wr_reg(2'd1, 8'h05);
        idle(); ca1 = 1'b1;
        rd_chk(2'd1, 8'h05, "R5 wrong edge");
        ca1 = 1'b0;
        rd_chk(2'd1, 8'h85, "R5 falling edge");
        chk(SRC_IRQ, 8'h02, "R7 irq a on");
        wr_reg(2'd1, 8'h45);
        rd_chk(2'd1, 8'h85, "R3 flags survive write");
        rd_chk(2'd0, 8'hAC, "R4 clearing read");
        rd_chk(2'd1, 8'h05, "R4 flags cleared");
        chk(SRC_IRQ, 8'h00, "R7 irq a off");

        // R4 read of direction register keeps flags
        idle(); ca1 = 1'b1;
        idle(); ca1 = 1'b0;
        wr_reg(2'd1, 8'h01);
        rd_chk(2'd0, 8'hF0, "R4 dir read");
        rd_chk(2'd1, 8'h81, "R4 flag kept");
        wr_reg(2'd1, 8'h05);
        rd_chk(2'd0, 8'hAC, "R4 clear");
        rd_chk(2'd1, 8'h05, "R4 cleared");

        // R7 masking
        wr_reg(2'd1, 8'h04);
        idle(); ca1 = 1'b1;
        idle(); ca1 = 1'b0;
        rd_chk(2'd1, 8'h84, "R7 flag set while masked");
        chk(SRC_IRQ, 8'h00, "R7 masked");
        wr_reg(2'd1, 8'h05);
        chk(SRC_IRQ, 8'h02, "R7 enable later");
        rd_chk(2'd0, 8'hAC, "R4 clear");
        rd_chk(2'd1, 8'h05, "R4 cleared");

        // R6 C2 input and output
        wr_reg(2'd3, 8'h1C);
        idle(); cb2_in = 1'b1;
        rd_chk(2'd3, 8'h5C, "R6 c2 rising");
        chk(SRC_IRQ, 8'h01, "R7 irq b from c2");
        rd_chk(2'd2, 8'h99, "R4 clear b");
        rd_chk(2'd3, 8'h1C, "R4 b cleared");
        wr_reg(2'd3, 8'h3C);
        chk(SRC_C2, 8'h03, "R8 level high");
        idle(); cb2_in = 1'b0;
        idle(); cb2_in = 1'b1;
        rd_chk(2'd3, 8'h3C, "R6 output ignores edges");
        wr_reg(2'd3, 8'h34);
        chk(SRC_C2, 8'h02, "R8 level low");

        // R9 side A strobe
        wr_reg(2'd1, 8'h2C);
        chk(SRC_C2, 8'h0E, "R9 idle high");
        rd_chk(2'd0, 8'hAC, "R9 strobe read");
        chk(SRC_C2, 8'h0A, "R9 low after read");
        idle();
        chk(SRC_C2, 8'h0E, "R9 one cycle");
        wr_reg(2'd1, 8'h24);
        rd_chk(2'd0, 8'hAC, "R9 strobe read c1");
        idle(); idle();
        chk(SRC_C2, 8'h0A, "R9 held low");
        ca1 = 1'b1; idle();
        chk(SRC_C2, 8'h0A, "R9 wrong edge");
        ca1 = 1'b0; idle();
        chk(SRC_C2, 8'h0E, "R9 c1 release");

        // R10 side B strobe
        wr_reg(2'd3, 8'h2C);
        chk(SRC_C2, 8'h0F, "R10 idle high");
        wr_reg(2'd2, 8'h77);
        chk(SRC_C2, 8'h0E, "R10 low after write");
        chk(SRC_PBO, 8'h77, "R10 latch");
        idle();
        chk(SRC_C2, 8'h0F, "R10 one cycle");
        wr_reg(2'd3, 8'h26);
        wr_reg(2'd2, 8'h11);
        chk(SRC_C2, 8'h0E, "R10 low");
        rd_chk(2'd2, 8'h99, "R10 read no flag");
        chk(SRC_C2, 8'h0E, "R10 no release without flag");
        cb1 = 1'b1; idle();
        chk(SRC_C2, 8'h0E, "R10 edge alone no release");
        rd_chk(2'd3, 8'hA6, "R10 flag set");
        rd_chk(2'd2, 8'h99, "R10 clearing read");
        chk(SRC_C2, 8'h0F, "R10 release on clear");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule